// File: doc/BRIEF.md
# SPI Master Channel Engine

This block is one channel of a multichannel SPI master. Software reaches it through five 32-bit registers: configuration, status, control, transmit and receive. The channel tracks two handshake flags, "transmit register empty" and "receive register full". Each write, read or enable event makes it decide whether one word may go out. If it may, the word is shifted over a mode-0 SPI port, most significant bit first, with the configured word length. The flags are then updated.

The channel drives a DMA request line for each direction. It also sends one-cycle TX-empty and RX-full event pulses to a separate interrupt block. The transfer mode sets which flags gate a transfer: full duplex, receive-only or transmit-only. A turbo bit lets a new word go out while the previous received word is still unread. When the shared `single_chan` input is high, words move on the wire only if the force bit is set. Otherwise the handshake flags update with no serial activity.

Control is a five-state machine:
- **IDLE** waits. Any trigger (TX write, RX read, enable 0→1), or a trigger held pending while busy, moves it to **EVAL**.
- **EVAL** → IDLE if the channel is disabled. → **NOTIFY** if the mode-dependent handshake blocks the transfer. → **SHIFT** if the wire may be used. → **FINISH** otherwise.
- **SHIFT** → FINISH when the last bit completes.
- **FINISH** updates the flags and → NOTIFY.
- **NOTIFY** issues the event pulses and → IDLE.

Top module: `spi_chan_engine`

## Requirements
- R1: After reset, bus reads return the following: address 0 (config) returns 0x0006_0000, address 1 (status) returns 0x2, address 2 (control) returns 0, and address 4 (RX) returns 0. `spi_cs_n` is high, `spi_sclk` is low, and both DMA request lines are low.
- R2: Config writes keep only bits 22:0. Writes to address 1 (status: bit 0 RX-full, bit 1 TX-empty, bit 2 end-of-transfer) and to address 4 (RX) have no effect.
- R3: No transfer starts while control bit 0 (enable) is clear. A control write that sets enable from 0 to 1 starts an evaluation, and a pending word then goes out.
- R4: A write to address 3 (TX) loads the word, clears TX-empty and starts an evaluation. After a transfer, the TX register reads 0 and both end-of-transfer and TX-empty are set.
- R5: In full duplex (config bits 13:12 = 0), a set RX-full blocks a new transfer unless turbo (config bit 19) is set. Reading RX returns the word, clears RX-full and re-evaluates, so a blocked word then goes out.
- R6: In receive-only mode (bits 13:12 = 1), TX-empty does not block a transfer. Enabling the channel, or reading RX, starts the next word.
- R7: In transmit-only mode (bits 13:12 = 2), RX-full does not gate a transfer and is not set by one, and no RX-full event fires.
- R8: A shifted word has length (config bits 11:7) + 1. It goes out MSB first on `spi_mosi`. `spi_miso` is sampled on rising `spi_sclk`, and `spi_cs_n` stays low for the whole word. The received word is right-justified in RX, with the upper bits zero.
- R9: With `single_chan` high and force (config bit 20) clear, a transfer updates the flags without lowering `spi_cs_n` and leaves RX unchanged. With force set, the word goes out on the wire.
- R10: The TX DMA request is high exactly when enable, config bit 14 and TX-empty are set and the mode is not 1. The RX DMA request is high exactly when enable, config bit 15 and RX-full are set and the mode is not 2.
- R11: Each evaluation of an enabled channel ends in one single-cycle NOTIFY step. In that step `ev_tx_empty` pulses if TX-empty is set and the mode is not 1. `ev_rx_full` pulses if RX-full is set, the mode is not 2 and turbo is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (an RX read has side effects) |
| bus_addr | input | 3 | Register select: 0 config, 1 status, 2 control, 3 TX, 4 RX |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| single_chan | input | 1 | Module-level single-channel mode |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, low during a word |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| ev_tx_empty | output | 1 | TX-empty event pulse |
| ev_rx_full | output | 1 | RX-full event pulse |

## Verification
The bench targets the cases where a flag should block a transfer, or should not:
- a set RX-full with and without turbo;
- a set TX-empty in receive-only mode;
- RX-full in transmit-only mode.

A design with the gating wrong would either lose an unread word or hang a transfer that should run. The bench also writes TX while the channel is disabled and then enables it, checking that the word waits and then goes out. Single-channel mode is checked with force clear and with force set: a wrong design would toggle the wire when it should not, or overwrite RX. Word lengths of 8, 16 and 32 bits confirm the bit count and the right-justified receive value.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_SHIFT,
        ST_FINISH,
        ST_NOTIFY
    } chan_state_t;

    localparam logic [2:0] ADDR_CONF = 3'd0;
    localparam logic [2:0] ADDR_STAT = 3'd1;
    localparam logic [2:0] ADDR_CTRL = 3'd2;
    localparam logic [2:0] ADDR_TXD  = 3'd3;
    localparam logic [2:0] ADDR_RXD  = 3'd4;

    localparam int BIT_WL_LO  = 7;
    localparam int BIT_WL_HI  = 11;
    localparam int BIT_MD_LO  = 12;
    localparam int BIT_MD_HI  = 13;
    localparam int BIT_DMA_TX = 14;
    localparam int BIT_DMA_RX = 15;
    localparam int BIT_TURBO  = 19;
    localparam int BIT_FORCE  = 20;

    localparam logic [31:0] CONF_MASK  = 32'h007F_FFFF;
    localparam logic [31:0] CONF_RESET = 32'h0006_0000;

    localparam logic [1:0] MODE_DUPLEX = 2'd0;
    localparam logic [1:0] MODE_RXONLY = 2'd1;
    localparam logic [1:0] MODE_TXONLY = 2'd2;
endpackage

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int DATA_W  = 32,
    parameter int CLK_DIV = 2,
    parameter int LEN_W   = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int DIV_W = $clog2(CLK_DIV) + 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic              active;
    logic              sclk_q;
    logic              done_q;
    logic [DIV_W-1:0]  div_cnt;
    logic [LEN_W-1:0]  bit_cnt;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] sh_out;
    logic [DATA_W-1:0] sh_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            len_q   <= '0;
            sh_out  <= '0;
            sh_in   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                sclk_q  <= 1'b0;
                div_cnt <= '0;
                bit_cnt <= '0;
                len_q   <= word_len;
                sh_out  <= tx_word << (DATA_W - int'(word_len));
                sh_in   <= '0;
            end else if (active) begin
                if (div_cnt == DIV_LAST) begin
                    div_cnt <= '0;
                    sclk_q  <= ~sclk_q;
                    if (!sclk_q) begin
                        sh_in <= {sh_in[DATA_W-2:0], miso};
                    end else begin
                        sh_out <= sh_out << 1;
                        if (bit_cnt == len_q - LEN_W'(1)) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + LEN_W'(1);
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + DIV_W'(1);
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = active & sh_out[DATA_W-1];
    assign cs_n    = ~active;
    assign done    = done_q;
    assign rx_word = sh_in;
endmodule

// File: rtl/spi_chan_fsm.sv
module spi_chan_fsm
    import spi_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eval_req,
    input  logic       en,
    input  logic       rxs,
    input  logic       txs,
    input  logic [1:0] mode,
    input  logic       turbo,
    input  logic       force_wire,
    input  logic       single_chan,
    input  logic       shift_done,
    output logic       start_shift,
    output logic       finish,
    output logic       notify
);
    chan_state_t state, state_nx;
    logic pend;
    logic blocked;
    logic wire_ok;

    assign blocked = (rxs && mode != MODE_TXONLY && !turbo) ||
                     (txs && mode != MODE_RXONLY);
    assign wire_ok = !single_chan || force_wire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pend  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) pend <= 1'b0;
            else if (eval_req)    pend <= 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (eval_req || pend) state_nx = ST_EVAL;
            ST_EVAL: begin
                if (!en)          state_nx = ST_IDLE;
                else if (blocked) state_nx = ST_NOTIFY;
                else if (wire_ok) state_nx = ST_SHIFT;
                else              state_nx = ST_FINISH;
            end
            ST_SHIFT:  if (shift_done) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_NOTIFY;
            ST_NOTIFY: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        start_shift = (state == ST_EVAL) && en && !blocked && wire_ok;
        finish      = (state == ST_FINISH);
        notify      = (state == ST_NOTIFY);
    end
endmodule

// File: rtl/spi_chan_engine.sv
module spi_chan_engine
    import spi_chan_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int CLK_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             single_chan,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n,
    output logic             dma_tx_req,
    output logic             dma_rx_req,
    output logic             ev_tx_empty,
    output logic             ev_rx_full
);
    localparam int LEN_W = $clog2(REG_W) + 1;

    logic [REG_W-1:0] cfg_q, tx_q, rx_q, rx_word;
    logic             en_q, txs_q, rxs_q, eot_q;
    logic             wr_conf, wr_ctrl, wr_tx, rd_rx, eval_req;
    logic             start_shift, shift_done, fin, notify;
    logic [1:0]       mode;
    logic             turbo;
    logic [LEN_W-1:0] word_len;

    assign wr_conf  = bus_wr && bus_addr == ADDR_CONF;
    assign wr_ctrl  = bus_wr && bus_addr == ADDR_CTRL;
    assign wr_tx    = bus_wr && bus_addr == ADDR_TXD;
    assign rd_rx    = bus_rd && bus_addr == ADDR_RXD;
    assign eval_req = wr_tx || rd_rx || (wr_ctrl && bus_wdata[0] && !en_q);

    assign mode     = cfg_q[BIT_MD_HI:BIT_MD_LO];
    assign turbo    = cfg_q[BIT_TURBO];
    assign word_len = LEN_W'(cfg_q[BIT_WL_HI:BIT_WL_LO]) + LEN_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CONF_RESET;
            en_q  <= 1'b0;
            txs_q <= 1'b1;
            rxs_q <= 1'b0;
            eot_q <= 1'b0;
            tx_q  <= '0;
            rx_q  <= '0;
        end else begin
            if (wr_conf)    cfg_q <= bus_wdata & CONF_MASK;
            if (wr_ctrl)    en_q  <= bus_wdata[0];
            if (shift_done) rx_q  <= rx_word;
            if (fin) begin
                tx_q  <= '0;
                eot_q <= 1'b1;
                txs_q <= 1'b1;
                if (mode != MODE_TXONLY) rxs_q <= 1'b1;
            end
            if (wr_tx) begin
                tx_q  <= bus_wdata;
                txs_q <= 1'b0;
            end
            if (rd_rx) rxs_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CONF: bus_rdata = cfg_q;
            ADDR_STAT: bus_rdata = {{(REG_W-3){1'b0}}, eot_q, txs_q, rxs_q};
            ADDR_CTRL: bus_rdata = {{(REG_W-1){1'b0}}, en_q};
            ADDR_TXD:  bus_rdata = tx_q;
            ADDR_RXD:  bus_rdata = rx_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign dma_tx_req  = en_q && cfg_q[BIT_DMA_TX] && txs_q && mode != MODE_RXONLY;
    assign dma_rx_req  = en_q && cfg_q[BIT_DMA_RX] && rxs_q && mode != MODE_TXONLY;
    assign ev_tx_empty = notify && txs_q && mode != MODE_RXONLY;
    assign ev_rx_full  = notify && rxs_q && mode != MODE_TXONLY && !turbo;

    spi_chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .eval_req   (eval_req),
        .en         (en_q),
        .rxs        (rxs_q),
        .txs        (txs_q),
        .mode       (mode),
        .turbo      (turbo),
        .force_wire (cfg_q[BIT_FORCE]),
        .single_chan(single_chan),
        .shift_done (shift_done),
        .start_shift(start_shift),
        .finish     (fin),
        .notify     (notify)
    );

    spi_shift_unit #(.DATA_W(REG_W), .CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_shift),
        .tx_word (tx_q),
        .word_len(word_len),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .done    (shift_done),
        .rx_word (rx_word)
    );
endmodule

// File: rtl/spi_chan_engine_chk.sv
module spi_chan_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        spi_cs_n,
    input logic        spi_sclk,
    input logic        ev_tx_empty,
    input logic        ev_rx_full,
    input logic        single_chan,
    input logic        en_q,
    input logic [31:0] cfg_q
);
    // R8: serial clock rests low whenever the slave is not selected
    a_r8_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R3: a word only starts on the wire from an enabled channel
    a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(en_q));

    // R9: wire activity in single-channel mode requires the force bit
    a_r9_wire_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (!$past(single_chan) || $past(cfg_q[20])));

    // R11: event outputs are single-cycle pulses
    a_r11_tx_event_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_empty |=> !ev_tx_empty);
    a_r11_rx_event_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_full |=> !ev_rx_full);
endmodule

bind spi_chan_engine spi_chan_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .ev_tx_empty(ev_tx_empty),
    .ev_rx_full (ev_rx_full),
    .single_chan(single_chan),
    .en_q       (en_q),
    .cfg_q      (cfg_q)
);

// File: tb/test_spi_chan_engine.sv
`timescale 1ns/1ps
module test_spi_chan_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        single_chan = 1'b0;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;
    logic        dma_tx_req, dma_rx_req, ev_tx_empty, ev_rx_full;

    int checks = 0, fails = 0;
    bit finished = 0;

    // slave model
    logic [31:0] slv_word = '0;
    int          slv_wl = 8;
    int          sidx = 0;
    logic [31:0] got = '0;
    int          rises = 0, cs_falls = 0;
    int          evt_tx = 0, evt_rx = 0;

    always #2.5 clk = ~clk;

    spi_chan_engine i_spi_chan_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .single_chan(single_chan), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .dma_tx_req(dma_tx_req),
        .dma_rx_req(dma_rx_req), .ev_tx_empty(ev_tx_empty), .ev_rx_full(ev_rx_full)
    );

    always @(negedge spi_cs_n) begin
        got = '0; rises = 0; cs_falls++;
        spi_miso = slv_word[slv_wl-1];
        sidx = slv_wl - 2;
    end
    always @(posedge spi_sclk) begin
        got = {got[30:0], spi_mosi};
        rises++;
    end
    always @(negedge spi_sclk) begin
        if (sidx >= 0) begin
            spi_miso = slv_word[sidx];
            sidx--;
        end
    end
    always @(negedge clk) begin
        if (ev_tx_empty) evt_tx++;
        if (ev_rx_full)  evt_rx++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (200) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); check("R1 config reset", v, 32'h0006_0000);
        rd(3'd1, v); check("R1 status reset", v, 32'h2);
        rd(3'd2, v); check("R1 control reset", v, 32'h0);
        rd(3'd4, v); check("R1 rx reset", v, 32'h0);
        check("R1 cs_n idle", {31'b0, spi_cs_n}, 32'h1);
        check("R1 sclk idle", {31'b0, spi_sclk}, 32'h0);
        check("R1 dma idle", {30'b0, dma_tx_req, dma_rx_req}, 32'h0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R2 config mask", v, 32'h007F_FFFF);
        wr(3'd1, 32'h0);
        rd(3'd1, v); check("R2 status read-only", v, 32'h2);
        wr(3'd4, 32'h1234);
        rd(3'd4, v); check("R2 rx read-only", v, 32'h0);
        wr(3'd0, 32'h0000_0380);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        int f0, etx, erx;
        f0 = cs_falls;
        slv_word = 32'h3C; slv_wl = 8;
        wr(3'd3, 32'hA5);
        settle();
        check("R3 no shift while disabled", cs_falls, f0);
        rd(3'd1, v); check("R4 tx write clears TX-empty", v, 32'h0);
        etx = evt_tx; erx = evt_rx;
        wr(3'd2, 32'h1);
        settle();
        check("R3 enable starts transfer", cs_falls, f0 + 1);
        check("R8 msb-first mosi word", got, 32'hA5);
        check("R8 eight clock rises", rises, 8);
        rd(3'd4, v); check("R8 rx right-justified", v, 32'h3C);
        // the RX read above cleared RX-full and re-evaluated (blocked by TX-empty)
        rd(3'd3, v); check("R4 tx cleared after transfer", v, 32'h0);
        check("R11 tx-empty events", evt_tx - etx, 2);
        check("R11 rx-full event", evt_rx - erx, 1);
    endtask

    task automatic t_rx_block();
        logic [31:0] v;
        int f0;
        slv_word = 32'h5A;
        wr(3'd3, 32'h44);
        settle();
        f0 = cs_falls;
        wr(3'd3, 32'h11);
        settle();
        check("R5 blocked by RX-full", cs_falls, f0);
        rd(3'd1, v); check("R5 status while blocked", v, 32'h5);
        slv_word = 32'h69;
        rd(3'd4, v); check("R5 rx data", v, 32'h5A);
        settle();
        check("R5 read releases word", cs_falls, f0 + 1);
        check("R5 released word on wire", got, 32'h11);
        rd(3'd1, v); check("R4 status after transfer", v, 32'h7);
    endtask

    task automatic t_dma();
        logic [31:0] v;
        wr(3'd0, 32'h0000_C380);
        @(negedge clk);
        check("R10 both dma requests", {30'b0, dma_tx_req, dma_rx_req}, 32'h3);
        rd(3'd4, v);
        settle();
        check("R10 rx dma drops after read", {30'b0, dma_tx_req, dma_rx_req}, 32'h2);
    endtask

    task automatic t_turbo();
        logic [31:0] v;
        int f0, erx;
        wr(3'd0, 32'h0008_0380);
        f0 = cs_falls; erx = evt_rx;
        wr(3'd3, 32'h22);
        settle();
        wr(3'd3, 32'h33);
        settle();
        check("R5 turbo ignores RX-full", cs_falls, f0 + 2);
        check("R5 turbo second word", got, 32'h33);
        check("R11 no rx-full event in turbo", evt_rx - erx, 0);
        rd(3'd1, v); check("R5 turbo status", v, 32'h7);
    endtask

    task automatic t_rx_only();
        logic [31:0] v;
        int f0;
        wr(3'd2, 32'h0);
        rd(3'd4, v);
        wr(3'd0, 32'h0000_5780);
        slv_word = 32'hBEEF; slv_wl = 16;
        f0 = cs_falls;
        wr(3'd2, 32'h1);
        settle();
        check("R6 rx-only starts with TX-empty", cs_falls, f0 + 1);
        check("R8 sixteen clock rises", rises, 16);
        rd(3'd1, v); check("R6 status", v, 32'h7);
        check("R10 no tx dma in rx-only", {31'b0, dma_tx_req}, 32'h0);
        slv_word = 32'h1234;
        rd(3'd4, v); check("R6 rx word", v, 32'hBEEF);
        settle();
        check("R6 rx read starts next word", cs_falls, f0 + 2);
        rd(3'd4, v); check("R6 second rx word", v, 32'h1234);
    endtask

    task automatic t_tx_only();
        logic [31:0] v;
        int erx;
        wr(3'd2, 32'h0);
        rd(3'd4, v);
        wr(3'd0, 32'h0000_2F80);
        slv_word = 32'hCAFE_F00D; slv_wl = 32;
        wr(3'd2, 32'h1);
        settle();
        erx = evt_rx;
        wr(3'd3, 32'hDEAD_BEEF);
        settle();
        check("R7 tx-only word out", got, 32'hDEAD_BEEF);
        check("R8 32 clock rises", rises, 32);
        rd(3'd1, v); check("R7 RX-full stays clear", v, 32'h6);
        check("R7 no rx-full event", evt_rx - erx, 0);
        rd(3'd4, v); check("R8 full-width rx", v, 32'hCAFE_F00D);
    endtask

    task automatic t_single();
        logic [31:0] v;
        int f0;
        wr(3'd0, 32'h0000_2380);
        single_chan = 1'b1;
        f0 = cs_falls;
        wr(3'd3, 32'h77);
        settle();
        check("R9 no wire activity", cs_falls, f0);
        rd(3'd1, v); check("R9 flags updated", v, 32'h6);
        rd(3'd4, v); check("R9 rx unchanged", v, 32'hCAFE_F00D);
        wr(3'd0, 32'h0010_0380);
        slv_word = 32'h99; slv_wl = 8;
        wr(3'd3, 32'h66);
        settle();
        check("R9 force drives wire", cs_falls, f0 + 1);
        check("R9 forced word", got, 32'h66);
        rd(3'd4, v); check("R9 forced rx", v, 32'h99);
        single_chan = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_enable();
        t_rx_block();
        t_dma();
        t_turbo();
        t_rx_only();
        t_tx_only();
        t_single();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule